// File: doc/BRIEF.md
# Dual-CPU Interrupt Control Latch

This block sits on the write path shared by two processors, here called CPU A and CPU B. Both can write to the same eight-location control window. A write there does not load a general register. Each location performs its own action, and it uses either the whole written byte or only its lowest bit. Through the window, software turns each CPU's maskable interrupt on or off and sets two coin-counter levels and a screen-flip level. Software also fires a one-clock non-maskable pulse at CPU B.

Once per frame a vertical-blank strobe raises each CPU's maskable request, but only for a CPU whose enable is set. The request then stays up until that CPU returns an acknowledge. Writing zero to an enable also withdraws a request that is already pending.

Each CPU also has a trigger port that interrupts the other CPU on its fast interrupt line. The block keeps the last byte written to each trigger port. A trigger fires only when that byte changes from zero to nonzero.

Every interrupt line is driven by a small request state machine with two states, `REQ_IDLE` and `REQ_PEND`. Its transitions are:
- `REQ_IDLE` to `REQ_PEND` on a raise.
- `REQ_PEND` to `REQ_IDLE` on a cancel, or on an acknowledge when no raise is present in the same clock.
- `REQ_PEND` stays in `REQ_PEND` on a raise, or when nothing happens.
- `REQ_IDLE` stays in `REQ_IDLE` on a cancel or on no event.

Top module: `cpu_pair_irq_latch`

## Requirements
- R1: After reset, every output is low, both maskable enables are off, and both stored trigger values are zero. As a result, the first nonzero trigger write after reset fires.
- R2: Either CPU writes the window with a strobe, a 3-bit offset and a byte. When both CPUs write the same offset in one clock, CPU B's byte takes effect. Writes to different offsets in one clock both take effect.
- R3: Offset 0 is CPU A's maskable enable and offset 6 is CPU B's. An enable is on when the written byte is nonzero. A vblank strobe sets the `irq` output of each CPU whose enable was on before that clock, and the output is high from the next clock.
- R4: A raised maskable request stays high until that CPU's `irq_ack` pulses, and it drops on the next clock. When vblank and ack arrive in the same clock, the request stays high.
- R5: Writing 0x00 to an enable offset drops that CPU's pending request on the next clock. This clear wins over a vblank strobe in the same clock.
- R6: Offsets 2 and 3 set `coin1` and `coin2` to bit 0 of the written byte.
- R7: Offset 5 sets `flip` to bit 0 of the written byte.
- R8: A write of any value to offset 7 makes `b_nmi` high for exactly the following clock.
- R9: Writes to offsets 1 and 4 change no output and no enable.
- R10: A write to CPU A's trigger port sets `b_firq` only when the byte stored from the previous write is zero and the new byte is nonzero. Every write to the port stores its byte.
- R11: CPU B's trigger port sets `a_firq` under the same zero-to-nonzero rule, using its own stored byte.
- R12: A fast request stays high until its `firq_ack` pulses. When a new firing and an ack arrive in the same clock, the request stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| a_wr | input | 1 | CPU A window write strobe |
| a_addr | input | 3 | CPU A window offset |
| a_data | input | 8 | CPU A write byte |
| a_trig_wr | input | 1 | CPU A trigger-port write (targets CPU B) |
| b_wr | input | 1 | CPU B window write strobe |
| b_addr | input | 3 | CPU B window offset |
| b_data | input | 8 | CPU B write byte |
| b_trig_wr | input | 1 | CPU B trigger-port write (targets CPU A) |
| vblank | input | 1 | One-clock frame strobe |
| a_irq_ack | input | 1 | CPU A maskable acknowledge |
| b_irq_ack | input | 1 | CPU B maskable acknowledge |
| a_firq_ack | input | 1 | CPU A fast acknowledge |
| b_firq_ack | input | 1 | CPU B fast acknowledge |
| a_irq | output | 1 | CPU A maskable request |
| b_irq | output | 1 | CPU B maskable request |
| a_firq | output | 1 | CPU A fast request |
| b_firq | output | 1 | CPU B fast request |
| b_nmi | output | 1 | One-clock non-maskable pulse to CPU B |
| coin1 | output | 1 | Coin counter 1 level |
| coin2 | output | 1 | Coin counter 2 level |
| flip | output | 1 | Screen flip level |

## Verification
The bench targets the clock where two events collide.

When a zero enable write and a vblank strobe arrive together, the clear must win. A design that ranks the raise first would leave a stale request behind. When vblank and an ack arrive together, the request must survive. A design that lets the ack win would silently lose a frame interrupt. The bench also writes an enable in the same clock as a vblank strobe, so a design that sampled the new enable would raise a request one frame early.

For the trigger ports, the bench repeats nonzero writes and also writes zero. Each of these must fire nothing. A design that fired on every nonzero write, or never stored the zero, fails these cases. Two further cases cover window collisions on one offset, where a design with the wrong CPU priority loses the check, and writes to the unused offsets, which must leave every level unchanged.

// File: rtl/irqlatch_pkg.sv
package irqlatch_pkg;

    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_PEND = 1'b1
    } req_state_t;

    localparam int unsigned OFS_EN_A  = 0;
    localparam int unsigned OFS_COIN1 = 2;
    localparam int unsigned OFS_COIN2 = 3;
    localparam int unsigned OFS_FLIP  = 5;
    localparam int unsigned OFS_EN_B  = 6;
    localparam int unsigned OFS_NMI_B = 7;

    typedef struct packed {
        logic en_a;
        logic en_b;
        logic coin1;
        logic coin2;
        logic flip;
    } ctrl_levels_t;

endpackage

// File: rtl/ctrl_window_decode.sv
module ctrl_window_decode #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned SLOTS = 1 << ADDR_W
) (
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_data,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_data,
    output logic [SLOTS-1:0]  slot_wr,
    output logic [DATA_W-1:0] slot_data [SLOTS]
);

    // One decoder per window location; CPU B wins a same-slot collision.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic hit_a;
        logic hit_b;

        always_comb begin
            hit_a = a_wr && (a_addr == ADDR_W'(s));
            hit_b = b_wr && (b_addr == ADDR_W'(s));
            slot_wr[s] = hit_a || hit_b;
            slot_data[s] = hit_b ? b_data : a_data;
        end
    end

endmodule

// File: rtl/firq_edge_trigger.sv
module firq_edge_trigger #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_wr,
    input  logic [DATA_W-1:0] trig_data,
    output logic              fire,
    output logic              prev_zero
);

    logic [DATA_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (trig_wr) begin
            last_q <= trig_data;
        end
    end

    always_comb begin
        prev_zero = (last_q == '0);
        fire = trig_wr && prev_zero && (trig_data != '0);
    end

endmodule

// File: rtl/irq_req_fsm.sv
module irq_req_fsm
    import irqlatch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic ack,
    input  logic cancel,
    output logic req
);

    req_state_t state_q;
    req_state_t state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= REQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic. A cancel wins over a raise, and a raise wins over an ack.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE: begin
                if (!cancel && raise) begin
                    state_d = REQ_PEND;
                end
            end
            REQ_PEND: begin
                if (cancel) begin
                    state_d = REQ_IDLE;
                end else if (raise) begin
                    state_d = REQ_PEND;
                end else if (ack) begin
                    state_d = REQ_IDLE;
                end
            end
            default: state_d = REQ_IDLE;
        endcase
    end

    // Output logic.
    always_comb begin
        req = (state_q == REQ_PEND);
    end

endmodule

// File: rtl/cpu_pair_irq_latch.sv
module cpu_pair_irq_latch
    import irqlatch_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_data,
    input  logic              a_trig_wr,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_data,
    input  logic              b_trig_wr,
    input  logic              vblank,
    input  logic              a_irq_ack,
    input  logic              b_irq_ack,
    input  logic              a_firq_ack,
    input  logic              b_firq_ack,
    output logic              a_irq,
    output logic              b_irq,
    output logic              a_firq,
    output logic              b_firq,
    output logic              b_nmi,
    output logic              coin1,
    output logic              coin2,
    output logic              flip
);

    localparam int unsigned SLOTS = 1 << ADDR_W;

    logic [SLOTS-1:0]  slot_wr;
    logic [DATA_W-1:0] slot_data [SLOTS];

    ctrl_levels_t lvl_q;
    logic         nmi_q;
    logic         cancel_a;
    logic         cancel_b;
    logic         fire_to_b;
    logic         fire_to_a;
    logic         prev_zero_a2b;
    logic         prev_zero_b2a;

    ctrl_window_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .a_wr      (a_wr),
        .a_addr    (a_addr),
        .a_data    (a_data),
        .b_wr      (b_wr),
        .b_addr    (b_addr),
        .b_data    (b_data),
        .slot_wr   (slot_wr),
        .slot_data (slot_data)
    );

    // Level registers written through the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
            nmi_q <= 1'b0;
        end else begin
            if (slot_wr[OFS_EN_A])  lvl_q.en_a  <= (slot_data[OFS_EN_A] != '0);
            if (slot_wr[OFS_EN_B])  lvl_q.en_b  <= (slot_data[OFS_EN_B] != '0);
            if (slot_wr[OFS_COIN1]) lvl_q.coin1 <= slot_data[OFS_COIN1][0];
            if (slot_wr[OFS_COIN2]) lvl_q.coin2 <= slot_data[OFS_COIN2][0];
            if (slot_wr[OFS_FLIP])  lvl_q.flip  <= slot_data[OFS_FLIP][0];
            nmi_q <= slot_wr[OFS_NMI_B];
        end
    end

    always_comb begin
        cancel_a = slot_wr[OFS_EN_A] && (slot_data[OFS_EN_A] == '0);
        cancel_b = slot_wr[OFS_EN_B] && (slot_data[OFS_EN_B] == '0);
    end

    irq_req_fsm u_irq_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .raise  (vblank && lvl_q.en_a),
        .ack    (a_irq_ack),
        .cancel (cancel_a),
        .req    (a_irq)
    );

    irq_req_fsm u_irq_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .raise  (vblank && lvl_q.en_b),
        .ack    (b_irq_ack),
        .cancel (cancel_b),
        .req    (b_irq)
    );

    firq_edge_trigger #(.DATA_W(DATA_W)) u_trig_a2b (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_wr   (a_trig_wr),
        .trig_data (a_data),
        .fire      (fire_to_b),
        .prev_zero (prev_zero_a2b)
    );

    firq_edge_trigger #(.DATA_W(DATA_W)) u_trig_b2a (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_wr   (b_trig_wr),
        .trig_data (b_data),
        .fire      (fire_to_a),
        .prev_zero (prev_zero_b2a)
    );

    irq_req_fsm u_firq_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .raise  (fire_to_b),
        .ack    (b_firq_ack),
        .cancel (1'b0),
        .req    (b_firq)
    );

    irq_req_fsm u_firq_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .raise  (fire_to_a),
        .ack    (a_firq_ack),
        .cancel (1'b0),
        .req    (a_firq)
    );

    always_comb begin
        b_nmi = nmi_q;
        coin1 = lvl_q.coin1;
        coin2 = lvl_q.coin2;
        flip  = lvl_q.flip;
    end

endmodule

// File: rtl/irq_latch_checker.sv
module irq_latch_checker #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_wr,
    input logic [ADDR_W-1:0] a_addr,
    input logic [DATA_W-1:0] a_data,
    input logic              a_trig_wr,
    input logic              b_wr,
    input logic [ADDR_W-1:0] b_addr,
    input logic [DATA_W-1:0] b_data,
    input logic              vblank,
    input logic              a_irq_ack,
    input logic              b_firq_ack,
    input logic              a_irq,
    input logic              b_firq,
    input logic              b_nmi,
    input logic              coin1,
    input logic              en_a,
    input logic              prev_zero_a2b
);

    logic nmi_hit;
    logic zero_a;

    always_comb begin
        nmi_hit = (a_wr && a_addr == ADDR_W'(7)) || (b_wr && b_addr == ADDR_W'(7));
        zero_a  = (a_wr && a_addr == ADDR_W'(0) && a_data == '0 && !(b_wr && b_addr == ADDR_W'(0)))
                || (b_wr && b_addr == ADDR_W'(0) && b_data == '0);
    end

    // R8
    nmi_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_hit |=> b_nmi);

    // R8
    nmi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_hit |=> !b_nmi);

    // R5
    cancel_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_a |=> !a_irq);

    // R3
    vblank_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && en_a && !zero_a) |=> a_irq);

    // R4
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_irq && !a_irq_ack && !zero_a) |=> a_irq);

    // R10
    firq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_trig_wr && prev_zero_a2b && a_data != '0) |=> b_firq);

    // R12
    firq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_firq && !b_firq_ack) |=> b_firq);

    // R6
    coin1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && a_addr == ADDR_W'(2) && !(b_wr && b_addr == ADDR_W'(2))) |=> (coin1 == $past(a_data[0])));

endmodule

bind cpu_pair_irq_latch irq_latch_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .a_wr          (a_wr),
    .a_addr        (a_addr),
    .a_data        (a_data),
    .a_trig_wr     (a_trig_wr),
    .b_wr          (b_wr),
    .b_addr        (b_addr),
    .b_data        (b_data),
    .vblank        (vblank),
    .a_irq_ack     (a_irq_ack),
    .b_firq_ack    (b_firq_ack),
    .a_irq         (a_irq),
    .b_firq        (b_firq),
    .b_nmi         (b_nmi),
    .coin1         (coin1),
    .en_a          (lvl_q.en_a),
    .prev_zero_a2b (prev_zero_a2b)
);

// File: tb/cpu_pair_irq_latch_tb.sv
module cpu_pair_irq_latch_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_wr = 1'b0, b_wr = 1'b0, a_trig_wr = 1'b0, b_trig_wr = 1'b0;
    logic [2:0] a_addr = '0, b_addr = '0;
    logic [7:0] a_data = '0, b_data = '0;
    logic       vblank = 1'b0;
    logic       a_irq_ack = 1'b0, b_irq_ack = 1'b0, a_firq_ack = 1'b0, b_firq_ack = 1'b0;
    logic       a_irq, b_irq, a_firq, b_firq, b_nmi, coin1, coin2, flip;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cpu_pair_irq_latch u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_wr(a_wr), .a_addr(a_addr), .a_data(a_data), .a_trig_wr(a_trig_wr),
        .b_wr(b_wr), .b_addr(b_addr), .b_data(b_data), .b_trig_wr(b_trig_wr),
        .vblank(vblank),
        .a_irq_ack(a_irq_ack), .b_irq_ack(b_irq_ack),
        .a_firq_ack(a_firq_ack), .b_firq_ack(b_firq_ack),
        .a_irq(a_irq), .b_irq(b_irq), .a_firq(a_firq), .b_firq(b_firq),
        .b_nmi(b_nmi), .coin1(coin1), .coin2(coin2), .flip(flip)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Inputs change at negedge; after the posedge the next negedge shows the result.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        a_wr = 0; b_wr = 0; a_trig_wr = 0; b_trig_wr = 0; vblank = 0;
        a_irq_ack = 0; b_irq_ack = 0; a_firq_ack = 0; b_firq_ack = 0;
    endtask

    task automatic wr_a(input logic [2:0] ad, input logic [7:0] d);
        a_wr = 1; a_addr = ad; a_data = d; step(); idle();
    endtask

    task automatic wr_b(input logic [2:0] ad, input logic [7:0] d);
        b_wr = 1; b_addr = ad; b_data = d; step(); idle();
    endtask

    task automatic pulse_vblank();
        vblank = 1; step(); idle();
    endtask

    task automatic t_reset();
        check("R1 a_irq", a_irq, 0); check("R1 b_irq", b_irq, 0);
        check("R1 a_firq", a_firq, 0); check("R1 b_firq", b_firq, 0);
        check("R1 b_nmi", b_nmi, 0); check("R1 coin1", coin1, 0);
        check("R1 coin2", coin2, 0); check("R1 flip", flip, 0);
        pulse_vblank();
        check("R1 enables off", a_irq | b_irq, 0);
    endtask

    task automatic t_enable_vblank();
        // enable write in the same clock as vblank: old enable (off) is used
        a_wr = 1; a_addr = 3'd0; a_data = 8'h01; vblank = 1; step(); idle();
        check("R3 old enable used", a_irq, 0);
        pulse_vblank();
        check("R3 a_irq raised", a_irq, 1);
        check("R3 b_irq stays off", b_irq, 0);
        wr_b(3'd6, 8'h80);
        pulse_vblank();
        check("R3 b_irq raised", b_irq, 1);
    endtask

    task automatic t_ack_hold();
        step();
        check("R4 held", a_irq, 1);
        vblank = 1; a_irq_ack = 1; step(); idle();
        check("R4 vblank beats ack", a_irq, 1);
        a_irq_ack = 1; b_irq_ack = 1; step(); idle();
        check("R4 ack clears a", a_irq, 0);
        check("R4 ack clears b", b_irq, 0);
    endtask

    task automatic t_cancel();
        pulse_vblank();
        check("R5 pending", a_irq, 1);
        a_wr = 1; a_addr = 3'd0; a_data = 8'h00; vblank = 1; step(); idle();
        check("R5 zero write clears", a_irq, 0);
        check("R5 b unaffected", b_irq, 1);
        pulse_vblank();
        check("R5 enable now off", a_irq, 0);
        wr_b(3'd6, 8'h00);
        check("R5 b cleared", b_irq, 0);
    endtask

    task automatic t_levels();
        wr_a(3'd2, 8'hFF);
        check("R6 coin1 set", coin1, 1);
        wr_b(3'd3, 8'h03);
        check("R6 coin2 set", coin2, 1);
        wr_a(3'd2, 8'hFE);
        check("R6 coin1 uses bit0", coin1, 0);
        wr_a(3'd5, 8'h01);
        check("R7 flip set", flip, 1);
        wr_b(3'd5, 8'h02);
        check("R7 flip uses bit0", flip, 0);
    endtask

    task automatic t_nmi();
        wr_a(3'd7, 8'h00);
        check("R8 nmi pulse", b_nmi, 1);
        step();
        check("R8 nmi one clock", b_nmi, 0);
        wr_b(3'd7, 8'h5A);
        check("R8 nmi from B", b_nmi, 1);
    endtask

    task automatic t_collision();
        a_wr = 1; a_addr = 3'd2; a_data = 8'h01;
        b_wr = 1; b_addr = 3'd2; b_data = 8'h00; step(); idle();
        check("R2 B wins same slot", coin1, 0);
        a_wr = 1; a_addr = 3'd2; a_data = 8'h01;
        b_wr = 1; b_addr = 3'd5; b_data = 8'h01; step(); idle();
        check("R2 both slots coin1", coin1, 1);
        check("R2 both slots flip", flip, 1);
    endtask

    task automatic t_ignored();
        // known state: coin1=1 coin2=1 flip=1, enables off
        wr_a(3'd1, 8'hFF);
        wr_b(3'd4, 8'h00);
        wr_a(3'd4, 8'hFF);
        check("R9 coin1 kept", coin1, 1);
        check("R9 coin2 kept", coin2, 1);
        check("R9 flip kept", flip, 1);
        check("R9 no nmi", b_nmi, 0);
        pulse_vblank();
        check("R9 enables untouched", a_irq | b_irq, 0);
    endtask

    task automatic trig_a(input logic [7:0] d);
        a_trig_wr = 1; a_data = d; step(); idle();
    endtask

    task automatic trig_b(input logic [7:0] d);
        b_trig_wr = 1; b_data = d; step(); idle();
    endtask

    task automatic t_firq();
        trig_a(8'h05);
        check("R10 first nonzero after reset fires", b_firq, 1);
        check("R10 a_firq untouched", a_firq, 0);
        b_firq_ack = 1; step(); idle();
        check("R12 ack clears b_firq", b_firq, 0);
        trig_a(8'h07);
        check("R10 nonzero to nonzero silent", b_firq, 0);
        trig_a(8'h00);
        check("R10 zero write silent", b_firq, 0);
        a_trig_wr = 1; a_data = 8'h01; b_firq_ack = 1; step(); idle();
        check("R12 fire beats ack", b_firq, 1);
        step();
        check("R12 held", b_firq, 1);
        trig_b(8'h00);
        check("R11 zero silent", a_firq, 0);
        trig_b(8'h40);
        check("R11 zero to nonzero fires", a_firq, 1);
        trig_b(8'h41);
        a_firq_ack = 1; step(); idle();
        check("R12 a ack clears", a_firq, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_enable_vblank();
        t_ack_hold();
        t_cancel();
        t_levels();
        t_nmi();
        t_collision();
        t_ignored();
        t_firq();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule